// File: doc/BRIEF.md
# Bus Ownership Handoff Controller

This block sits beside a processor's bus unit and decides who drives the shared system bus. An external master asks for the bus by pulling an active-low request line low. The controller waits until the processor's current bus cycle has finished, as reported by a busy flag from the bus unit. It then pulls an active-low grant line low and waits for the external master to confirm through an active-low acknowledge line.

While the bus is offered or held by the other master, the controller withdraws the enable of the processor's address and data drivers. The external master keeps ownership for as long as it holds acknowledge low. The processor takes the bus back only after request and acknowledge have both returned high. If the requester gives up before it acknowledges, the offer is cancelled and the processor keeps the bus.

Request and acknowledge come from another clock domain, so each passes through a synchronizer of `SYNC_STAGES` flops (default 2). The busy flag comes from the same clock domain and is used directly. There is only one external requester, so no priority scheme is involved.

Top module: `bus_handoff_ctl`

## Requirements
- R1: During and right after reset, `phase` is 2'b00 (processor owns the bus), `bus_grant_n` is high and `bus_drv_oe` is high.
- R2: With `cycle_busy` low, a request (`bus_req_n` driven low at a falling edge) changes `phase` to 2'b01 and drives `bus_grant_n` low at exactly the (SYNC_STAGES+1)-th rising clock edge after the change, and not earlier.
- R3: `bus_grant_n` never falls while `cycle_busy` is high. When `cycle_busy` falls with a synchronized request pending, `phase` becomes 2'b01 at the first rising edge after the change.
- R4: In phase 2'b01, an acknowledge (`bus_ack_n` low) moves `phase` to 2'b10 and releases `bus_grant_n` high at the (SYNC_STAGES+1)-th rising edge after it changes.
- R5: `bus_drv_oe` is low whenever `phase` is 2'b01 or 2'b10, and high in phase 2'b00.
- R6: In phase 2'b10, releasing only one of request or acknowledge leaves `phase` at 2'b10 and `bus_drv_oe` low.
- R7: In phase 2'b10, once both request and acknowledge are high, `phase` returns to 2'b00 and `bus_drv_oe` rises at the (SYNC_STAGES+1)-th rising edge after the second release. The phase never goes from 2'b10 to 2'b01.
- R8: If request returns high in phase 2'b01 before any acknowledge, `phase` returns to 2'b00 and `bus_grant_n` goes high at the (SYNC_STAGES+1)-th rising edge after the release.
- R9: An acknowledge with no request, seen in phase 2'b00, has no effect: `phase` stays 2'b00 and `bus_grant_n` stays high.
- R10: `phase` never takes the value 2'b11, and the processor phase 2'b00 is never followed directly by 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req_n | input | 1 | Active-low bus request from the external master (asynchronous) |
| bus_ack_n | input | 1 | Active-low grant acknowledge from the external master (asynchronous) |
| cycle_busy | input | 1 | High while the processor's bus unit is inside a bus cycle |
| bus_grant_n | output | 1 | Active-low grant to the external master |
| bus_drv_oe | output | 1 | Output enable of the processor's address and data drivers, high when it drives |
| phase | output | 2 | 00 processor-owned, 01 granted and waiting, 10 external-owned |

## Verification
The bench raises a request in the middle of a long processor bus cycle. A design that ignored the busy flag would grant early, and one that sampled it late would miss the single-edge handoff. It drops the request before any acknowledge arrives, which catches a controller that stays stuck offering the bus. In external ownership it releases request and acknowledge one at a time, in both orders, because a design that reclaimed on either release alone would fight the other master for the bus. It also sends an acknowledge with no request, and it times every transition to the exact edge so that a missing or extra synchronizer stage shows up.

// File: rtl/bus_handoff_pkg.sv
package bus_handoff_pkg;

  // Ownership phase; encoding is visible on the phase port.
  typedef enum logic [1:0] {
    PH_LOCAL   = 2'b00,  // processor drives the bus
    PH_OFFERED = 2'b01,  // grant asserted, waiting for acknowledge
    PH_REMOTE  = 2'b10   // external master owns the bus
  } phase_e;

  localparam int unsigned HANDSHAKE_LINES = 2;  // request and acknowledge

endpackage

// File: rtl/bus_handoff_sync.sv
// Multi-flop synchronizer for asynchronous handshake lines.
module bus_handoff_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign q = d;
    end else begin : g_chain
      logic [WIDTH-1:0] stg [STAGES];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < int'(STAGES); i++) stg[i] <= '0;
        end else begin
          stg[0] <= d;
          for (int i = 1; i < int'(STAGES); i++) stg[i] <= stg[i-1];
        end
      end

      assign q = stg[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/bus_handoff_fsm.sv
// Ownership state machine: request / grant / acknowledge handshake.
module bus_handoff_fsm
  import bus_handoff_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req_on,    // synchronized, active-high request
  input  logic   ack_on,    // synchronized, active-high acknowledge
  input  logic   busy,      // processor bus cycle in progress
  output phase_e phase_q
);

  phase_e phase_d;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_LOCAL: begin
        // only hand over at a cycle boundary
        if (req_on && !busy) phase_d = PH_OFFERED;
      end
      PH_OFFERED: begin
        // acknowledge wins over a simultaneous withdrawal
        if (ack_on)       phase_d = PH_REMOTE;
        else if (!req_on) phase_d = PH_LOCAL;
      end
      PH_REMOTE: begin
        if (!req_on && !ack_on) phase_d = PH_LOCAL;
      end
      default: phase_d = PH_LOCAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_LOCAL;
    else        phase_q <= phase_d;
  end

endmodule

// File: rtl/bus_handoff_pins.sv
// Decodes the ownership phase into the pin-level controls.
module bus_handoff_pins
  import bus_handoff_pkg::*;
(
  input  phase_e     phase_q,
  output logic       grant_n,
  output logic       drv_oe,
  output logic [1:0] phase_code
);

  always_comb begin
    grant_n    = 1'b1;
    drv_oe     = 1'b0;
    unique case (phase_q)
      PH_LOCAL:   drv_oe  = 1'b1;
      PH_OFFERED: grant_n = 1'b0;
      PH_REMOTE:  ;
      default:    ;
    endcase
    phase_code = phase_q;
  end

endmodule

// File: rtl/bus_handoff_ctl.sv
// Top: processor-side bus ownership handoff controller.
module bus_handoff_ctl
  import bus_handoff_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_req_n,
  input  logic       bus_ack_n,
  input  logic       cycle_busy,
  output logic       bus_grant_n,
  output logic       bus_drv_oe,
  output logic [1:0] phase
);

  localparam int unsigned LW = HANDSHAKE_LINES;

  logic [LW-1:0] hs_raw;
  logic [LW-1:0] hs_sync;
  phase_e        phase_q;

  // convert to active-high so a reset value of zero means idle
  assign hs_raw = {~bus_ack_n, ~bus_req_n};

  bus_handoff_sync #(
    .WIDTH  (LW),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (hs_raw),
    .q     (hs_sync)
  );

  bus_handoff_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_on  (hs_sync[0]),
    .ack_on  (hs_sync[1]),
    .busy    (cycle_busy),
    .phase_q (phase_q)
  );

  bus_handoff_pins u_pins (
    .phase_q    (phase_q),
    .grant_n    (bus_grant_n),
    .drv_oe     (bus_drv_oe),
    .phase_code (phase)
  );

endmodule

// File: rtl/bus_handoff_chk.sv
module bus_handoff_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cycle_busy,
  input logic       bus_grant_n,
  input logic       bus_drv_oe,
  input logic [1:0] phase
);

  // R3: grant only falls after a cycle with the bus unit idle
  a_r3_no_grant_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_grant_n) |-> !$past(cycle_busy));

  // R5: processor drivers are off while the grant is out
  a_r5_oe_off_when_granted: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_grant_n |-> !bus_drv_oe);

  // R10: illegal phase code never appears
  a_r10_legal_phase: assert property (@(posedge clk) disable iff (!rst_n)
    phase != 2'b11);

  // R10: processor phase only leaves toward the offered phase
  a_r10_local_exit: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase) == 2'b00 && phase != 2'b00) |-> (phase == 2'b01 && !bus_grant_n));

  // R7: external ownership ends only by returning to the processor
  a_r7_remote_exit: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase) == 2'b10 && phase != 2'b10) |-> (phase == 2'b00 && bus_drv_oe));

endmodule

bind bus_handoff_ctl bus_handoff_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cycle_busy  (cycle_busy),
  .bus_grant_n (bus_grant_n),
  .bus_drv_oe  (bus_drv_oe),
  .phase       (phase)
);

// File: tb/tb_bus_handoff_ctl.sv
`timescale 1ns/1ps
module tb_bus_handoff_ctl;

  localparam int unsigned SYNC = 2;
  localparam int LAT = SYNC + 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_req_n = 1'b1;
  logic       bus_ack_n = 1'b1;
  logic       cycle_busy = 1'b0;
  logic       bus_grant_n;
  logic       bus_drv_oe;
  logic [1:0] phase;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [1:0] exp_q[$];

  always #2 clk = ~clk;  // 250 MHz

  bus_handoff_ctl #(.SYNC_STAGES(SYNC)) dut (
    .clk (clk), .rst_n (rst_n), .bus_req_n (bus_req_n), .bus_ack_n (bus_ack_n),
    .cycle_busy (cycle_busy), .bus_grant_n (bus_grant_n), .bus_drv_oe (bus_drv_oe),
    .phase (phase)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive inputs away from the rising edge
  task automatic drive(input logic req_n, input logic ack_n, input logic busy);
    @(negedge clk);
    bus_req_n  = req_n;
    bus_ack_n  = ack_n;
    cycle_busy = busy;
  endtask

  // expect a phase change exactly lat rising edges after the last drive
  task automatic expect_after(input int lat, input logic [1:0] oldp,
                              input logic [1:0] newp, input string tag);
    exp_q.push_back(newp);
    #1 chk({tag, " before"}, {6'd0, phase}, {6'd0, oldp});
    for (int i = 0; i < lat - 1; i++) @(posedge clk);
    #1 chk({tag, " early"}, {6'd0, phase}, {6'd0, oldp});
    @(posedge clk);
    #1 chk({tag, " on time"}, {6'd0, phase}, {6'd0, newp});
  endtask

  // expect no change for n cycles
  task automatic expect_hold(input int n, input logic [1:0] p, input string tag);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
    chk({tag, " phase"}, {6'd0, phase}, {6'd0, p});
    chk({tag, " grant_n"}, {7'd0, bus_grant_n}, {7'd0, (p != 2'b01)});
    chk({tag, " oe"}, {7'd0, bus_drv_oe}, {7'd0, (p == 2'b00)});
  endtask

  // monitor: every phase change must match the next expected item
  logic [1:0] last_phase = 2'b00;
  always @(negedge clk) begin
    if (rst_n && phase !== last_phase) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R10 unexpected phase change actual=%0h expected=%0h", phase, last_phase);
      end else begin
        logic [1:0] e;
        e = exp_q.pop_front();
        chk("R10 scoreboard phase", {6'd0, phase}, {6'd0, e});
        chk("R5 scoreboard oe", {7'd0, bus_drv_oe}, {7'd0, (e == 2'b00)});
        chk("R2 R4 scoreboard grant_n", {7'd0, bus_grant_n}, {7'd0, (e != 2'b01)});
      end
    end
    last_phase = phase;
  end

  initial begin
    for (int i = 0; i < 60000; i++) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog all requirements actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    #1;
    chk("R1 phase in reset", {6'd0, phase}, 8'h00);
    chk("R1 grant_n in reset", {7'd0, bus_grant_n}, 8'h01);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    expect_hold(2, 2'b00, "R1 after reset");

    // R2, R4: full handoff; R6: request released first
    drive(1'b0, 1'b1, 1'b0);
    expect_after(LAT, 2'b00, 2'b01, "R2 grant latency");
    drive(1'b0, 1'b0, 1'b0);
    expect_after(LAT, 2'b01, 2'b10, "R4 ack to remote");
    expect_hold(4, 2'b10, "R5 remote oe off");
    drive(1'b1, 1'b0, 1'b0);
    expect_hold(8, 2'b10, "R6 only request released");
    drive(1'b1, 1'b1, 1'b0);
    expect_after(LAT, 2'b10, 2'b00, "R7 reclaim");
    expect_hold(4, 2'b00, "R7 settled");

    // R6: acknowledge released first, request still held
    drive(1'b0, 1'b1, 1'b0);
    expect_after(LAT, 2'b00, 2'b01, "R2 second grant");
    drive(1'b0, 1'b0, 1'b0);
    expect_after(LAT, 2'b01, 2'b10, "R4 second ack");
    drive(1'b0, 1'b1, 1'b0);
    expect_hold(8, 2'b10, "R6 only ack released");
    drive(1'b1, 1'b1, 1'b0);
    expect_after(LAT, 2'b10, 2'b00, "R7 reclaim after request");

    // R3: request during a long bus cycle
    drive(1'b0, 1'b1, 1'b1);
    expect_hold(12, 2'b00, "R3 held off while busy");
    drive(1'b0, 1'b1, 1'b0);
    expect_after(1, 2'b00, 2'b01, "R3 grant after busy clears");

    // R8: withdraw before acknowledge
    drive(1'b1, 1'b1, 1'b0);
    expect_after(LAT, 2'b01, 2'b00, "R8 withdrawn request");
    expect_hold(4, 2'b00, "R8 settled");

    // R9: stray acknowledge with no request
    drive(1'b1, 1'b0, 1'b0);
    expect_hold(10, 2'b00, "R9 stray ack ignored");
    drive(1'b1, 1'b1, 1'b0);
    expect_hold(5, 2'b00, "R9 stray ack released");

    chk("R10 no pending expectations", exp_q.size() == 0 ? 8'h01 : 8'h00, 8'h01);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule